// File: doc/BRIEF.md
# Trap-Return State Restore Unit

This unit performs the two ways of leaving a trap handler: "done", which resumes at the instruction after the trapped one, and "retry", which re-executes the trapped instruction. On a strobe it reads the saved trap-state entry for the current trap level. From that entry it restores, all in one clock edge, the program counter pair, the condition-code byte, the address space identifier, the processor-state field and the window pointer. When a hypervisor is present it also restores the global-register level and the hypervisor state. It then reports the trap level lowered by one.

The saved entry (PC, next-PC, packed trap-state word, hypervisor-state word) and the current trap level are presented as inputs by the trap stack that sits outside this block. The unit holds the restored values in registers until the next accepted operation. A strobe issued at trap level zero, or a cycle with both strobes raised, is refused with a one-cycle error pulse and leaves every restored field as it was. Re-evaluation of pending interrupts and the physical swap of register banks belong to neighbouring blocks.

Top module: `trapret_unit`

## Requirements
- R1: While rst_n is low and after its release, every output is zero until the first accepted operation.
- R2: A done operation loads pc_o with the saved next-PC and npc_o with the saved next-PC plus 4, with the sum taken modulo 2^PC_W.
- R3: A retry operation loads pc_o with the saved PC and npc_o with the saved next-PC.
- R4: An accepted operation loads ccr_o from trap-state bits 39:32 and asi_o from trap-state bits 31:24.
- R5: An accepted operation loads pstate_o from trap-state bits 19:8 ANDed with 12'hF3F, so field bits 7:6 always read zero.
- R6: An accepted operation sets cwp_o to NWIN-1 minus (trap-state bits 7:0 modulo NWIN), for example raw 3 gives 4 and raw 255 gives 0 when NWIN is 8.
- R7: When hv_present_i is high, an accepted operation loads gl_o from trap-state bits 42:40 and hpstate_o from saved_hstate_i. When it is low, both keep their previous values.
- R8: An accepted operation sets tl_o to cur_tl_i minus 1. It raises valid_o for exactly the following cycle, and all restored fields change on that same edge.
- R9: A done or retry strobe with cur_tl_i equal to 0 raises err_o for the following cycle, keeps valid_o low and changes no other output.
- R10: A cycle with done_i and retry_i both high is refused. err_o rises for the following cycle, valid_o stays low and no other output changes.
- R11: In a cycle with neither strobe high, every restored output holds its value and valid_o and err_o are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 1 | Done strobe |
| retry_i | input | 1 | Retry strobe |
| hv_present_i | input | 1 | Hypervisor present; enables global-level and hypervisor-state restore |
| cur_tl_i | input | TL_W | Current trap level |
| saved_pc_i | input | PC_W | Saved PC of the current trap level |
| saved_npc_i | input | PC_W | Saved next-PC of the current trap level |
| saved_tstate_i | input | 64 | Saved packed trap-state word |
| saved_hstate_i | input | HS_W | Saved hypervisor state of the current trap level |
| pc_o | output | PC_W | Restored PC |
| npc_o | output | PC_W | Restored next-PC |
| ccr_o | output | 8 | Restored condition codes |
| asi_o | output | 8 | Restored address space identifier |
| pstate_o | output | 12 | Restored processor state |
| cwp_o | output | $clog2(NWIN) | Restored window pointer in internal order |
| gl_o | output | 3 | Restored global-register level |
| hpstate_o | output | HS_W | Restored hypervisor state |
| tl_o | output | TL_W | New trap level |
| valid_o | output | 1 | One-cycle pulse for an accepted operation |
| err_o | output | 1 | One-cycle pulse for a refused operation |

## Verification
Two cases can land in the same cycle. The first is a done and a retry strobe together. The second is a strobe that arrives at trap level zero, and it can also coincide with the first. The random stimulus raises both strobes in about one cycle in eight and draws level zero about as often, so both overlaps occur many times. Directed cases force each overlap in isolation. In each of these cycles the bench expects an error pulse with no valid pulse. It also expects every restored field, including the trap level, to match its prior value. Accepted operations are judged field by field against a bench model that also keeps track of hypervisor presence.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

  // Decoded request class for one cycle
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_DONE  = 2'd1,
    OP_RETRY = 2'd2,
    OP_BAD   = 2'd3
  } trapret_op_e;

  // Field positions inside the packed trap-state word
  localparam int TS_W       = 64;
  localparam int CCR_LSB    = 32;
  localparam int ASI_LSB    = 24;
  localparam int PST_LSB    = 8;
  localparam int CWP_LSB    = 0;
  localparam int GL_LSB     = 40;
  localparam int BYTE_W     = 8;
  localparam int PST_W      = 12;
  localparam int GL_W       = 3;
  localparam logic [PST_W-1:0] PST_MASK = 12'hF3F;
  localparam int NPC_STEP   = 4;

endpackage

// File: rtl/trapret_ctrl.sv
module trapret_ctrl
  import trapret_pkg::*;
#(
  parameter int TL_W = 3
) (
  input  logic            done_i,
  input  logic            retry_i,
  input  logic [TL_W-1:0] cur_tl_i,
  output trapret_op_e     op_o,
  output logic            upd_o,
  output logic            bad_o,
  output logic [TL_W-1:0] tl_next_o
);

  trapret_op_e op_raw;

  always_comb begin
    if (done_i && retry_i) begin
      op_raw = OP_BAD;
    end else if (done_i) begin
      op_raw = OP_DONE;
    end else if (retry_i) begin
      op_raw = OP_RETRY;
    end else begin
      op_raw = OP_NONE;
    end
  end

  always_comb begin
    op_o = op_raw;
    if ((op_raw == OP_DONE || op_raw == OP_RETRY) && cur_tl_i == '0) begin
      op_o = OP_BAD;
    end
  end

  assign upd_o     = (op_o == OP_DONE) || (op_o == OP_RETRY);
  assign bad_o     = (op_o == OP_BAD);
  assign tl_next_o = cur_tl_i - TL_W'(1);

endmodule

// File: rtl/trapret_pc_sel.sv
module trapret_pc_sel
  import trapret_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  trapret_op_e     op_i,
  input  logic [PC_W-1:0] saved_pc_i,
  input  logic [PC_W-1:0] saved_npc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);

  always_comb begin
    if (op_i == OP_DONE) begin
      pc_o  = saved_npc_i;
      npc_o = saved_npc_i + PC_W'(NPC_STEP);
    end else begin
      pc_o  = saved_pc_i;
      npc_o = saved_npc_i;
    end
  end

endmodule

// File: rtl/trapret_unpack.sv
module trapret_unpack
  import trapret_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic [TS_W-1:0]   tstate_i,
  output logic [BYTE_W-1:0] ccr_o,
  output logic [BYTE_W-1:0] asi_o,
  output logic [PST_W-1:0]  pstate_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [GL_W-1:0]   gl_o
);

  logic [BYTE_W-1:0] cwp_raw;
  logic [BYTE_W-1:0] cwp_rem;
  logic              unused_bits;

  assign ccr_o    = tstate_i[CCR_LSB +: BYTE_W];
  assign asi_o    = tstate_i[ASI_LSB +: BYTE_W];
  assign pstate_o = tstate_i[PST_LSB +: PST_W] & PST_MASK;
  assign gl_o     = tstate_i[GL_LSB +: GL_W];

  // Out-of-range window numbers wrap, then the order is reversed
  assign cwp_raw  = tstate_i[CWP_LSB +: BYTE_W];
  assign cwp_rem  = cwp_raw % BYTE_W'(NWIN);
  assign cwp_o    = CWP_W'(NWIN - 1) - CWP_W'(cwp_rem);

  assign unused_bits = ^{tstate_i[TS_W-1:GL_LSB+GL_W], tstate_i[ASI_LSB-1:PST_LSB+PST_W]};

endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int NWIN  = 8,
  parameter int TL_W  = 3,
  parameter int HS_W  = 12,
  localparam int CWP_W = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              retry_i,
  input  logic              hv_present_i,
  input  logic [TL_W-1:0]   cur_tl_i,
  input  logic [PC_W-1:0]   saved_pc_i,
  input  logic [PC_W-1:0]   saved_npc_i,
  input  logic [63:0]       saved_tstate_i,
  input  logic [HS_W-1:0]   saved_hstate_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [7:0]        ccr_o,
  output logic [7:0]        asi_o,
  output logic [11:0]       pstate_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [2:0]        gl_o,
  output logic [HS_W-1:0]   hpstate_o,
  output logic [TL_W-1:0]   tl_o,
  output logic              valid_o,
  output logic              err_o
);

  trapret_op_e       op;
  logic              upd;
  logic              bad;
  logic [TL_W-1:0]   tl_next;
  logic [PC_W-1:0]   pc_sel, npc_sel;
  logic [BYTE_W-1:0] ccr_f, asi_f;
  logic [PST_W-1:0]  pst_f;
  logic [CWP_W-1:0]  cwp_f;
  logic [GL_W-1:0]   gl_f;

  // Next-state values
  logic [PC_W-1:0]   pc_d, npc_d;
  logic [BYTE_W-1:0] ccr_d, asi_d;
  logic [PST_W-1:0]  pst_d;
  logic [CWP_W-1:0]  cwp_d;
  logic [GL_W-1:0]   gl_d;
  logic [HS_W-1:0]   hs_d;
  logic [TL_W-1:0]   tl_d;

  // Registers
  logic [PC_W-1:0]   pc_q, npc_q;
  logic [BYTE_W-1:0] ccr_q, asi_q;
  logic [PST_W-1:0]  pst_q;
  logic [CWP_W-1:0]  cwp_q;
  logic [GL_W-1:0]   gl_q;
  logic [HS_W-1:0]   hs_q;
  logic [TL_W-1:0]   tl_q;
  logic              valid_q, err_q;

  trapret_ctrl #(.TL_W(TL_W)) u_ctrl (
    .done_i    (done_i),
    .retry_i   (retry_i),
    .cur_tl_i  (cur_tl_i),
    .op_o      (op),
    .upd_o     (upd),
    .bad_o     (bad),
    .tl_next_o (tl_next)
  );

  trapret_pc_sel #(.PC_W(PC_W)) u_pc_sel (
    .op_i        (op),
    .saved_pc_i  (saved_pc_i),
    .saved_npc_i (saved_npc_i),
    .pc_o        (pc_sel),
    .npc_o       (npc_sel)
  );

  trapret_unpack #(.NWIN(NWIN), .CWP_W(CWP_W)) u_unpack (
    .tstate_i (saved_tstate_i),
    .ccr_o    (ccr_f),
    .asi_o    (asi_f),
    .pstate_o (pst_f),
    .cwp_o    (cwp_f),
    .gl_o     (gl_f)
  );

  always_comb begin
    pc_d  = pc_q;
    npc_d = npc_q;
    ccr_d = ccr_q;
    asi_d = asi_q;
    pst_d = pst_q;
    cwp_d = cwp_q;
    gl_d  = gl_q;
    hs_d  = hs_q;
    tl_d  = tl_q;
    if (upd) begin
      pc_d  = pc_sel;
      npc_d = npc_sel;
      ccr_d = ccr_f;
      asi_d = asi_f;
      pst_d = pst_f;
      cwp_d = cwp_f;
      tl_d  = tl_next;
      if (hv_present_i) begin
        gl_d = gl_f;
        hs_d = saved_hstate_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      npc_q   <= '0;
      ccr_q   <= '0;
      asi_q   <= '0;
      pst_q   <= '0;
      cwp_q   <= '0;
      gl_q    <= '0;
      hs_q    <= '0;
      tl_q    <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= upd;
      err_q   <= bad;
      if (upd) begin
        pc_q  <= pc_d;
        npc_q <= npc_d;
        ccr_q <= ccr_d;
        asi_q <= asi_d;
        pst_q <= pst_d;
        cwp_q <= cwp_d;
        gl_q  <= gl_d;
        hs_q  <= hs_d;
        tl_q  <= tl_d;
      end
    end
  end

  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign ccr_o     = ccr_q;
  assign asi_o     = asi_q;
  assign pstate_o  = pst_q;
  assign cwp_o     = cwp_q;
  assign gl_o      = gl_q;
  assign hpstate_o = hs_q;
  assign tl_o      = tl_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;

endmodule

// File: rtl/trapret_chk.sv
module trapret_chk #(
  parameter int PC_W  = 64,
  parameter int NWIN  = 8,
  parameter int TL_W  = 3,
  parameter int HS_W  = 12,
  localparam int CWP_W = $clog2(NWIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_i,
  input logic              retry_i,
  input logic              hv_present_i,
  input logic [TL_W-1:0]   cur_tl_i,
  input logic [PC_W-1:0]   saved_pc_i,
  input logic [PC_W-1:0]   saved_npc_i,
  input logic [63:0]       saved_tstate_i,
  input logic [HS_W-1:0]   saved_hstate_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [PC_W-1:0]   npc_o,
  input logic [7:0]        ccr_o,
  input logic [7:0]        asi_o,
  input logic [11:0]       pstate_o,
  input logic [CWP_W-1:0]  cwp_o,
  input logic [2:0]        gl_o,
  input logic [HS_W-1:0]   hpstate_o,
  input logic [TL_W-1:0]   tl_o,
  input logic              valid_o,
  input logic              err_o
);

  logic good_done, good_retry, good_op, refused;
  assign good_done  = done_i && !retry_i && cur_tl_i != '0;
  assign good_retry = retry_i && !done_i && cur_tl_i != '0;
  assign good_op    = good_done || good_retry;
  assign refused    = (done_i && retry_i) || ((done_i || retry_i) && cur_tl_i == '0);

  // R2
  done_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_done |=> (pc_o == $past(saved_npc_i)) && (npc_o == $past(saved_npc_i) + PC_W'(4)));

  // R3
  retry_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_retry |=> (pc_o == $past(saved_pc_i)) && (npc_o == $past(saved_npc_i)));

  // R4
  ccr_asi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_op |=> (ccr_o == $past(saved_tstate_i[39:32])) && (asi_o == $past(saved_tstate_i[31:24])));

  // R5
  pstate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pstate_o[7:6] == 2'b00));

  // R7
  hv_absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_op && !hv_present_i) |=> $stable(gl_o) && $stable(hpstate_o));

  // R8
  tl_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_op |=> valid_o && !err_o && (tl_o == TL_W'($past(cur_tl_i) - TL_W'(1))));

  // R9
  // R10
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> err_o && !valid_o && $stable(pc_o) && $stable(npc_o) && $stable(tl_o)
                && $stable(cwp_o) && $stable(pstate_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !retry_i) |=> !valid_o && !err_o && $stable(pc_o) && $stable(tl_o) && $stable(ccr_o));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, err_o}));

endmodule

bind trapret_unit trapret_chk #(.PC_W(PC_W), .NWIN(NWIN), .TL_W(TL_W), .HS_W(HS_W)) u_chk (.*);

// File: tb/tb_trapret_unit.sv
module tb_trapret_unit;

  localparam int PC_W  = 64;
  localparam int NWIN  = 8;
  localparam int TL_W  = 3;
  localparam int HS_W  = 12;
  localparam int CWP_W = $clog2(NWIN);

  logic              clk;
  logic              rst_n;
  logic              done_i, retry_i, hv_present_i;
  logic [TL_W-1:0]   cur_tl_i;
  logic [PC_W-1:0]   saved_pc_i, saved_npc_i;
  logic [63:0]       saved_tstate_i;
  logic [HS_W-1:0]   saved_hstate_i;
  logic [PC_W-1:0]   pc_o, npc_o;
  logic [7:0]        ccr_o, asi_o;
  logic [11:0]       pstate_o;
  logic [CWP_W-1:0]  cwp_o;
  logic [2:0]        gl_o;
  logic [HS_W-1:0]   hpstate_o;
  logic [TL_W-1:0]   tl_o;
  logic              valid_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench model of the registered state
  logic [PC_W-1:0]  e_pc, e_npc;
  logic [7:0]       e_ccr, e_asi;
  logic [11:0]      e_pst;
  logic [CWP_W-1:0] e_cwp;
  logic [2:0]       e_gl;
  logic [HS_W-1:0]  e_hs;
  logic [TL_W-1:0]  e_tl;
  logic             e_valid, e_err;

  trapret_unit #(.PC_W(PC_W), .NWIN(NWIN), .TL_W(TL_W), .HS_W(HS_W)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [CWP_W-1:0] model_cwp(input logic [7:0] raw);
    int r;
    r = int'(raw) % NWIN;
    return CWP_W'(NWIN - 1 - r);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "pc",      64'(pc_o),      64'(e_pc));
    chk(req, "npc",     64'(npc_o),     64'(e_npc));
    chk(req, "ccr",     64'(ccr_o),     64'(e_ccr));
    chk(req, "asi",     64'(asi_o),     64'(e_asi));
    chk(req, "pstate",  64'(pstate_o),  64'(e_pst));
    chk(req, "cwp",     64'(cwp_o),     64'(e_cwp));
    chk(req, "gl",      64'(gl_o),      64'(e_gl));
    chk(req, "hpstate", 64'(hpstate_o), 64'(e_hs));
    chk(req, "tl",      64'(tl_o),      64'(e_tl));
    chk(req, "valid",   64'(valid_o),   64'(e_valid));
    chk(req, "err",     64'(err_o),     64'(e_err));
  endtask

  // Drive one cycle at the falling edge, update the model, sample at the next falling edge
  task automatic run_op(input logic d, input logic r, input logic hv, input logic [TL_W-1:0] tl,
                        input logic [PC_W-1:0] spc, input logic [PC_W-1:0] snpc,
                        input logic [63:0] ts, input logic [HS_W-1:0] hs, input string req);
    bit good, bad;
    done_i = d; retry_i = r; hv_present_i = hv; cur_tl_i = tl;
    saved_pc_i = spc; saved_npc_i = snpc; saved_tstate_i = ts; saved_hstate_i = hs;
    good = (d ^ r) && (tl != '0);
    bad  = (d && r) || ((d || r) && tl == '0);
    e_valid = good;
    e_err   = bad;
    if (good) begin
      if (d) begin
        e_pc  = snpc;
        e_npc = snpc + PC_W'(4);
      end else begin
        e_pc  = spc;
        e_npc = snpc;
      end
      e_ccr = ts[39:32];
      e_asi = ts[31:24];
      e_pst = ts[19:8] & 12'hF3F;
      e_cwp = model_cwp(ts[7:0]);
      e_tl  = tl - TL_W'(1);
      if (hv) begin
        e_gl = ts[42:40];
        e_hs = hs;
      end
    end
    @(posedge clk);
    @(negedge clk);
    done_i = 1'b0; retry_i = 1'b0;
    check_all(req);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    rst_n = 1'b0;
    done_i = 0; retry_i = 0; hv_present_i = 0; cur_tl_i = '0;
    saved_pc_i = '0; saved_npc_i = '0; saved_tstate_i = '0; saved_hstate_i = '0;
    e_pc = '0; e_npc = '0; e_ccr = '0; e_asi = '0; e_pst = '0; e_cwp = '0;
    e_gl = '0; e_hs = '0; e_tl = '0; e_valid = 0; e_err = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // Directed corners
    // R9: level zero refused
    run_op(1, 0, 1, 3'd0, 64'h1000, 64'h1004, 64'h0000_07FF_FFFF_FFFF, 12'hABC, "R9");
    // R2: done with next-PC wrap, R6 raw 255 -> 0, R5 full mask
    run_op(1, 0, 1, 3'd1, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_05A5_C3FF_FFFF, 12'h123, "R2");
    // R3: retry, R6 raw 3 -> 4, R8 top level 7 -> 6
    run_op(0, 1, 1, 3'd7, 64'h4444_0000, 64'h4444_0004, 64'h0000_0312_7700_0003, 12'h456, "R3");
    // R7: hypervisor absent keeps gl and hpstate
    run_op(1, 0, 0, 3'd2, 64'h10, 64'h20, 64'h0000_0700_0000_0009, 12'hFFF, "R7");
    // R10: both strobes refused
    run_op(1, 1, 1, 3'd5, 64'h99, 64'h9C, 64'hFFFF_FFFF_FFFF_FFFF, 12'h777, "R10");
    // R10 with level zero at once
    run_op(1, 1, 1, 3'd0, 64'h77, 64'h7B, 64'h1234_5678_9ABC_DEF0, 12'h111, "R10");
    // R11: idle cycle
    run_op(0, 0, 1, 3'd4, 64'h55, 64'h59, 64'h0000_0600_0000_0001, 12'h222, "R11");
    // R4: field isolation with single ones
    run_op(0, 1, 1, 3'd1, 64'h8, 64'hC, 64'h0000_0081_8000_0100, 12'h001, "R4");

    // Constrained random traffic
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic d, r;
      sel = int'($urandom() % 8);
      d = (sel <= 2) || (sel == 6);
      r = (sel >= 3 && sel <= 6);
      run_op(d, r, logic'($urandom() % 2), TL_W'($urandom()),
             rnd64(), rnd64(), rnd64(), HS_W'($urandom()), "R8");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule